// File: doc/BRIEF.md
# Serial ADC frame reader

This block is the host side of a three-wire link to a 24-bit delta-sigma converter that is clocked externally, one conversion per read. When asked by `start_i`, it pulls chip select low and watches the data line. The converter shows its end-of-conversion flag on that line while it is selected and not clocked. While a conversion is still running, the reader releases chip select, waits a programmable gap and tries again.

Once the flag shows the result is ready, the reader keeps chip select low and produces exactly 32 serial clock cycles from a divided system clock. It shifts in the frame most significant bit first and then releases the converter, which starts its next conversion on the last falling edge. The reader removes the leading flag, checks the three fixed status bits, drops the four trailing sub-LSB bits and reports the 24-bit code with a one-cycle valid pulse.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst_n` is low, and from then until the first request, `csn_o` is 1, `sck_o` is 0, `valid_o` is 0, and `result_o` and all fault flags are 0. A reset in the middle of a read returns the block to this state at once.
- R2: `start_i` is taken only when the block is idle and is ignored during a read, so one request yields exactly one `valid_o` pulse. If `start_i` is high in the cycle `valid_o` is reported, `csn_o` falls on the next cycle.
- R3: `sck_o` is 0 in every cycle in which `csn_o` is 1, and in the cycle `csn_o` falls, so the converter always selects external clocking.
- R4: A poll holds `csn_o` low for `settle_i`+1 cycles with no serial clock edge, and `sdo_i` is sampled in the last of them. A 1 releases `csn_o` for `gap_i`+1 cycles before the next poll. A 0 begins the read without releasing `csn_o`.
- R5: Each high phase and each low phase of `sck_o` inside a read lasts H = max(`sck_half_i`,1) system cycles. The first rising edge comes H cycles after the read begins, with `csn_o` already low.
- R6: A read has exactly 32 rising edges of `sck_o`. `csn_o` rises in the same cycle as the 32nd falling edge, and a poll has no edge.
- R7: `sdo_i` is sampled at each rising edge of `sck_o`. The first sample is frame bit 31 (the end-of-conversion flag) and the last is bit 0. `result_o` is frame bits 27:4 with bit 27 as its MSB, and bits 3:0 are dropped.
- R8: The fault flags are set as follows: `flt_dmy_o` = 1 when frame bit 30 is 1, `flt_sig_o` = 1 when frame bit 29 is 0, and `flt_exr_o` = 1 when frame bit 28 is 1.
- R9: `valid_o` is high for one cycle, in the cycle after the first cycle with `csn_o` high at the end of a read. `result_o` and the flags stay unchanged between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion result |
| sck_half_i | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| settle_i | input | CNT_W | Extra cycles of chip select low before the flag is sampled |
| gap_i | input | CNT_W | Extra cycles of chip select high between polls |
| sdo_i | input | 1 | Serial data and end-of-conversion flag from the converter |
| csn_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | 24 | Conversion code, frame bits 27:4 |
| flt_dmy_o | output | 1 | Always-zero status bit was read as 1 |
| flt_sig_o | output | 1 | Sign bit was read as 0 |
| flt_exr_o | output | 1 | Range bit was read as 1 |

## Verification
The 32nd falling edge of the serial clock, the release of chip select and the start of the converter's next conversion all happen in one cycle. The bench converter model starts its busy period on that exact edge, and a monitor checks that chip select rises exactly when the clock falls for the last time. A second collision arises when `start_i` is held high through the result pulse, so reporting one result and accepting the next request fall together. The bench checks that chip select falls in the cycle right after `valid_o` and that both back-to-back reads return their own frames.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_BITS = 32;
    localparam int SUB_BITS   = 4;
    localparam int STAT_BITS  = 4;
    localparam int RES_BITS   = FRAME_BITS - SUB_BITS - STAT_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_WAIT,
        ST_SHIFT,
        ST_DONE
    } rd_state_e;

endpackage

// File: rtl/adc_sck_tick.sv
module adc_sck_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
        tick_o   = en_i && (cnt_q == half_eff - DIV_W'(1));
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_frame_split.sv
module adc_frame_split
    import adc_rd_pkg::*;
#(
    parameter int IN_W = FRAME_BITS - 1 - SUB_BITS
) (
    input  logic [IN_W-1:0]     body_i,
    output logic [RES_BITS-1:0] result_o,
    output logic                flt_dmy_o,
    output logic                flt_sig_o,
    output logic                flt_exr_o
);

    // body_i holds frame bits 30 down to SUB_BITS: three status bits, then the code
    always_comb begin
        result_o  = body_i[RES_BITS-1:0];
        flt_exr_o = body_i[RES_BITS];
        flt_sig_o = !body_i[RES_BITS+1];
        flt_dmy_o = body_i[RES_BITS+2];
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DIV_W-1:0]    sck_half_i,
    input  logic [CNT_W-1:0]    settle_i,
    input  logic [CNT_W-1:0]    gap_i,
    input  logic                sdo_i,
    output logic                csn_o,
    output logic                sck_o,
    output logic                valid_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                flt_dmy_o,
    output logic                flt_sig_o,
    output logic                flt_exr_o
);

    localparam int BIT_W  = $clog2(FRAME_BITS + 1);
    localparam int SHR_W  = FRAME_BITS - 1;
    localparam int BODY_W = SHR_W - SUB_BITS;

    typedef struct packed {
        rd_state_e           state;
        logic                csn;
        logic                sck;
        logic [CNT_W-1:0]    timer;
        logic [BIT_W-1:0]    bits;
        logic [SHR_W-1:0]    shreg;
        logic                valid;
        logic [RES_BITS-1:0] result;
        logic                dmy;
        logic                sig;
        logic                exr;
    } rd_regs_t;

    rd_regs_t d, q;

    logic                tick;
    logic [RES_BITS-1:0] split_res;
    logic                split_dmy, split_sig, split_exr;

    adc_sck_tick #(
        .DIV_W (DIV_W)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (q.state == ST_SHIFT),
        .half_i (sck_half_i),
        .tick_o (tick)
    );

    adc_frame_split #(
        .IN_W (BODY_W)
    ) i_split (
        .body_i    (q.shreg[SHR_W-1:SUB_BITS]),
        .result_o  (split_res),
        .flt_dmy_o (split_dmy),
        .flt_sig_o (split_sig),
        .flt_exr_o (split_exr)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                d.csn = 1'b1;
                d.sck = 1'b0;
                if (start_i) begin
                    d.state = ST_POLL;
                    d.csn   = 1'b0;
                    d.timer = '0;
                end
            end
            ST_POLL: begin
                if (q.timer == settle_i) begin
                    if (!sdo_i) begin
                        d.state = ST_SHIFT;
                        d.bits  = '0;
                    end else begin
                        d.state = ST_WAIT;
                        d.csn   = 1'b1;
                        d.timer = '0;
                    end
                end else begin
                    d.timer = q.timer + CNT_W'(1);
                end
            end
            ST_WAIT: begin
                if (q.timer == gap_i) begin
                    d.state = ST_POLL;
                    d.csn   = 1'b0;
                    d.timer = '0;
                end else begin
                    d.timer = q.timer + CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck   = 1'b1;
                        d.shreg = {q.shreg[SHR_W-2:0], sdo_i};
                    end else begin
                        d.sck  = 1'b0;
                        d.bits = q.bits + BIT_W'(1);
                        if (q.bits == BIT_W'(FRAME_BITS - 1)) begin
                            d.state = ST_DONE;
                            d.csn   = 1'b1;
                        end
                    end
                end
            end
            ST_DONE: begin
                d.valid  = 1'b1;
                d.result = split_res;
                d.dmy    = split_dmy;
                d.sig    = split_sig;
                d.exr    = split_exr;
                d.state  = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
                d.csn   = 1'b1;
                d.sck   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.csn   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign csn_o     = q.csn;
    assign sck_o     = q.sck;
    assign valid_o   = q.valid;
    assign result_o  = q.result;
    assign flt_dmy_o = q.dmy;
    assign flt_sig_o = q.sig;
    assign flt_exr_o = q.exr;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk
    import adc_rd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                csn_o,
    input logic                sck_o,
    input logic                valid_o,
    input logic [RES_BITS-1:0] result_o,
    input logic                flt_dmy_o,
    input logic                flt_sig_o,
    input logic                flt_exr_o
);

    localparam int EC_W = $clog2(FRAME_BITS + 1);

    logic [EC_W-1:0] edge_cnt_q;
    logic            sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_o;
            if (csn_o) begin
                edge_cnt_q <= '0;
            end else if (sck_o && !sck_prev_q) begin
                edge_cnt_q <= edge_cnt_q + EC_W'(1);
            end
        end
    end

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sck_o); // R3

    AST_SCK_LOW_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csn_o) |-> (!sck_o && !$past(sck_o))); // R3

    AST_RISE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> (!csn_o && !$past(csn_o))); // R5

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> (edge_cnt_q == EC_W'(0) || edge_cnt_q == EC_W'(FRAME_BITS))); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9

    AST_VALID_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (csn_o && $past(csn_o))); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(result_o) && $stable(flt_dmy_o)
                      && $stable(flt_sig_o) && $stable(flt_exr_o))); // R9

endmodule

bind adc_frame_reader adc_frame_reader_chk i_chk (.*);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

    typedef struct packed {
        logic [31:0] frame;
        logic [7:0]  half;
        logic [15:0] settle;
        logic [15:0] gap;
        logic [15:0] busy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h2ABCDEF7, 8'd2, 16'd1, 16'd3, 16'd0},
        '{32'h2000000F, 8'd1, 16'd0, 16'd0, 16'd30},
        '{32'h3FFFFFF0, 8'd3, 16'd2, 16'd5, 16'd40},
        '{32'h08000015, 8'd0, 16'd3, 16'd1, 16'd12},
        '{32'h65A5A5AA, 8'd4, 16'd0, 16'd2, 16'd0},
        '{32'h51234569, 8'd2, 16'd5, 16'd0, 16'd25}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half = 8'd2;
    logic [15:0] settle = 16'd0;
    logic [15:0] gap = 16'd0;
    logic        sdo;
    logic        csn, sck, valid, f_dmy, f_sig, f_exr;
    logic [23:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sck_half_i (half),
        .settle_i   (settle),
        .gap_i      (gap),
        .sdo_i      (sdo),
        .csn_o      (csn),
        .sck_o      (sck),
        .valid_o    (valid),
        .result_o   (result),
        .flt_dmy_o  (f_dmy),
        .flt_sig_o  (f_sig),
        .flt_exr_o  (f_exr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [31:0] mframe = 32'h0;
    int conv_left = 0;
    int idx = 31;

    assign sdo = csn ? 1'b1 : ((idx == 31) ? (conv_left != 0) : mframe[idx]);

    always @(posedge clk) if (conv_left > 0) conv_left <= conv_left - 1;

    always @(negedge csn) begin
        idx = 31;
        if (rst_n) chk(!sck, "R3", "sck at select", 32'(sck), 0);
    end

    always @(negedge sck) begin
        if (!csn && rst_n) begin
            if (idx == 0) conv_left <= 5; // 32nd falling edge starts a conversion
            else idx = idx - 1;
        end
    end

    // ---------------- monitor ----------------
    int  cyc = 0, low_len = 0, high_len = 0, edges = 0;
    int  hi_run = 0, lo_run = 0, rise_cyc = -10, csn_falls = 0, valid_cnt = 0;
    bit  csn_prev = 1'b1, sck_prev = 1'b0, seen_rise = 1'b0, last_poll = 1'b0, valid_prev = 1'b0;

    function automatic int eff_half();
        return (half == 0) ? 1 : int'(half);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            csn_prev = 1'b1; sck_prev = 1'b0; seen_rise = 1'b0; last_poll = 1'b0;
            low_len = 0; high_len = 0; edges = 0; valid_prev = 1'b0;
        end else begin
            if (!csn && sck && !sck_prev) begin
                if (seen_rise) chk(lo_run == eff_half(), "R5", "low phase", lo_run, eff_half());
                else chk(lo_run >= eff_half(), "R5", "first rise delay", lo_run, eff_half());
                seen_rise = 1'b1; hi_run = 0; edges++;
            end
            if (!sck && sck_prev) begin
                chk(hi_run == eff_half(), "R5", "high phase", hi_run, eff_half());
                lo_run = 0;
            end
            if (!csn && csn_prev) begin
                if (last_poll) chk(high_len == int'(gap) + 1, "R4", "gap length", high_len, int'(gap) + 1);
                csn_falls++; low_len = 0; edges = 0; lo_run = 0;
            end
            if (csn && !csn_prev) begin
                if (edges == 0) begin
                    chk(low_len == int'(settle) + 1, "R4", "poll length", low_len, int'(settle) + 1);
                    last_poll = 1'b1;
                end else begin
                    chk(edges == 32, "R6", "edges per read", edges, 32);
                    chk(sck_prev, "R6", "release with last fall", 32'(sck_prev), 1);
                    last_poll = 1'b0; rise_cyc = cyc;
                end
                high_len = 0; seen_rise = 1'b0;
            end
            if (csn) high_len++; else low_len++;
            if (sck) hi_run++; else lo_run++;
            if (valid) begin
                valid_cnt++;
                chk(csn && cyc == rise_cyc + 1, "R9", "valid timing", cyc - rise_cyc, 1);
                chk(!valid_prev, "R9", "valid width", 32'(valid_prev), 0);
            end
            csn_prev = csn; sck_prev = sck; valid_prev = valid;
        end
    end

    // ---------------- helpers ----------------
    task automatic setup(input vec_t v);
        @(negedge clk);
        half = v.half; settle = v.settle; gap = v.gap;
        mframe = v.frame;
        conv_left <= int'(v.busy);
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic check_frame(input logic [31:0] f, input string tag);
        chk(result == f[27:4], "R7", {tag, " result"}, 32'(result), 32'(f[27:4]));
        chk(f_dmy == f[30], "R8", {tag, " dmy"}, 32'(f_dmy), 32'(f[30]));
        chk(f_sig == !f[29], "R8", {tag, " sig"}, 32'(f_sig), 32'(!f[29]));
        chk(f_exr == f[28], "R8", {tag, " exr"}, 32'(f_exr), 32'(f[28]));
    endtask

    task automatic one_read(input vec_t v, input string tag);
        bit got;
        setup(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid(got);
        chk(got, "R9", {tag, " valid seen"}, 32'(got), 1);
        if (got) begin
            check_frame(v.frame, tag);
            repeat (5) @(negedge clk);
            chk(result == v.frame[27:4], "R9", {tag, " result held"}, 32'(result), 32'(v.frame[27:4]));
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit got;
        int vc, falls;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(csn && !sck && !valid, "R1", "reset outputs", {29'd0, csn, sck, valid}, 32'h4);
        chk(result == 0 && !f_dmy && !f_sig && !f_exr, "R1", "reset result", 32'(result), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(csn && !sck && !valid, "R1", "idle before request", {29'd0, csn, sck, valid}, 32'h4);

        // table of reads: R4, R5, R6, R7, R8 through monitor and result checks
        for (int k = 0; k < NV; k++) one_read(VECS[k], $sformatf("vec%0d", k));

        // R2: start during a read is ignored
        vc = valid_cnt;
        setup(VECS[0]);
        conv_left <= 20;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_valid(got);
        falls = csn_falls;
        repeat (300) @(negedge clk);
        chk(valid_cnt == vc + 1, "R2", "one valid per request", valid_cnt - vc, 1);
        chk(csn_falls == falls, "R2", "no select after read", csn_falls - falls, 0);
        check_frame(VECS[0].frame, "busy start");

        // R2: start held through the valid pulse
        setup(VECS[2]);
        conv_left <= 0;
        start = 1'b1;
        wait_valid(got);
        chk(got && csn, "R2", "csn high at valid", 32'(csn), 1);
        check_frame(VECS[2].frame, "b2b first");
        @(negedge clk);
        chk(!csn, "R2", "select right after valid", 32'(csn), 0);
        start = 1'b0;
        mframe = VECS[4].frame;
        wait_valid(got);
        chk(got, "R2", "second read", 32'(got), 1);
        check_frame(VECS[4].frame, "b2b second");

        // R1: reset during the shift phase
        setup(VECS[1]);
        conv_left <= 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int i = 0; i < 200 && !sck; i++) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(csn && !sck && !valid, "R1", "mid-read reset", {29'd0, csn, sck, valid}, 32'h4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        one_read(VECS[5], "after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule